// File: doc/BRIEF.md
# Decode-Resolved Next-Fetch-Address and Squash Unit

This unit owns the fetch address register and the fetch-to-decode buffer of a five-stage in-order pipeline. Fetch always assumes straight-line flow and asks for the word at the current address plus one, with no stall. Control-flow instructions are resolved once they reach the decode/register-read stage. They are the two-register conditional skip, the absolute jump, the register-indirect call and the return through the link register. When such an instruction changes the flow, the unit loads the new fetch address. On the same clock edge it writes an all-zero no-operation word into the decode buffer in place of the one word that was fetched behind it.

Outside the unit, the register file supplies the two operand values named by the decoded word, already forwarded, and the current content of register 15. The unit returns the call link value, the decoded word's address plus one, which the writeback path stores into register 15. A stall input freezes the fetch address and the buffer. A halt instruction in decode stops all further fetch until reset.

Top module: `fetch_redirect_unit`

## Requirements
- R1: After reset, `pc` is 0, `decInstr` is the all-zero no-operation word, `decPc` is 0, and `halted` and `flush` are 0.
- R2: With no stall and a non-control word in decode, `nextPc` equals `pc + 1`. At the clock edge `pc` takes that value, and the buffer captures `fetchInstr` together with the old `pc` as `decPc`.
- R3: The opcode is bits [31:28] and the skip opcode is 0011. The skip mode is bits [27:24]. In mode 0 the skip is taken when `opA != opB`. A taken skip sets `nextPc` to `decPc + 2`. A skip that is not taken continues at `pc + 1`.
- R4: In skip mode 1 the skip is taken when `opA <= opB`, with both operands compared as signed 32-bit two's complement. Any mode other than 0 or 1 never skips.
- R5: For opcode 0100 (absolute jump), `nextPc` is bits [23:0] of the decoded word, zero-extended.
- R6: For opcode 1100 (call), `nextPc` is `opA`, the value of the register named in bits [27:24]. `linkValue` always equals `decPc + 1`.
- R7: For opcode 1101 (return), `nextPc` is `raVal`, and `opA` has no effect.
- R8: `flush` is high, with no stall, exactly while a taken skip, jump, call or return sits in decode. After that edge `decInstr` is 0 and not the fetched word.
- R9: While `stall` is high, `pc`, `decInstr` and `decPc` hold, `nextPc` equals `pc`, and `flush` is low. A pending redirect takes effect only once the stall drops.
- R10: Opcode 1111 (halt) in decode without stall sets `halted` at the next edge, and it stays set until reset. From that edge on, `pc` holds and `decInstr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze fetch address and decode buffer |
| fetchInstr | input | 32 | Word returned by instruction memory at `pc` |
| opA | input | 32 | Forwarded value of the first source (or call target) register of the decoded word |
| opB | input | 32 | Forwarded value of the second source register of the decoded word |
| raVal | input | 32 | Forwarded value of register 15 |
| pc | output | 32 | Current fetch address |
| decInstr | output | 32 | Word held in the decode buffer |
| decPc | output | 32 | Address of the word held in the decode buffer |
| nextPc | output | 32 | Address loaded into `pc` at the next edge |
| flush | output | 1 | Redirect strobe; the fetched word is squashed this edge |
| halted | output | 1 | Fetch stopped by a halt instruction |
| linkValue | output | 32 | Call link value, `decPc + 1` |

## Verification
The assertions assume that `opA`, `opB` and `raVal` are valid for the word currently in `decInstr`, and that `stall` comes only from a hazard unit that eventually releases it. The assertions check stall holds, squash-to-zero, skip distance, sequential increment and halt stickiness as relations between cycles. The bench resets before each table row, so every decoded word sits at address 0 with `pc` at 1. It changes operands and `stall` only at falling edges, so every operand is stable for the whole decode cycle. Signed skip boundaries, such as the most negative against the most positive value, and the undefined skip modes are covered by table rows. Stall, halt and nonzero-address link values are covered by directed sequences.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam logic [3:0] OPC_SKIP = 4'b0011;
  localparam logic [3:0] OPC_JUMP = 4'b0100;
  localparam logic [3:0] OPC_CALL = 4'b1100;
  localparam logic [3:0] OPC_RET  = 4'b1101;
  localparam logic [3:0] OPC_HALT = 4'b1111;

  localparam logic [3:0] MODE_NE = 4'h0;
  localparam logic [3:0] MODE_LE = 4'h1;

  typedef enum logic [2:0] {
    SEL_HOLD  = 3'd0,
    SEL_SEQ   = 3'd1,
    SEL_SKIP2 = 3'd2,
    SEL_ABS   = 3'd3,
    SEL_REGA  = 3'd4,
    SEL_LINK  = 3'd5
  } tgt_sel_e;

  typedef struct packed {
    tgt_sel_e sel;      // source of the next fetch address
    logic     bufLoad;  // decode buffer captures this edge
    logic     squash;   // buffer captures the no-operation word
    logic     flush;    // redirect strobe
  } npc_ctl_t;

endpackage

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int JMP_W = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  npc_ctl_t        ctl,
  input  logic [XLEN-1:0] fetchInstr,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [XLEN-1:0] raVal,
  output logic [XLEN-1:0] pcQ,
  output logic [XLEN-1:0] bufInstr,
  output logic [XLEN-1:0] bufPc,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] linkValue,
  output logic [3:0]      opcode,
  output logic [3:0]      mode,
  output logic            neFlag,
  output logic            leFlag
);

  localparam int OPC_HI  = XLEN - 1;
  localparam int MODE_HI = XLEN - 5;
  localparam logic [XLEN-1:0] ONE = XLEN'(1);
  localparam logic [XLEN-1:0] TWO = XLEN'(2);

  // Field extraction from the decode buffer
  assign opcode = bufInstr[OPC_HI -: 4];
  assign mode   = bufInstr[MODE_HI -: 4];

  // Operand comparison for the skip test
  assign neFlag = (opA != opB);
  assign leFlag = ($signed(opA) <= $signed(opB));

  assign linkValue = bufPc + ONE;

  // Next fetch address selection
  always_comb begin
    case (ctl.sel)
      SEL_HOLD:  nextPc = pcQ;
      SEL_SEQ:   nextPc = pcQ + ONE;
      SEL_SKIP2: nextPc = bufPc + TWO;
      SEL_ABS:   nextPc = XLEN'(bufInstr[JMP_W-1:0]);
      SEL_REGA:  nextPc = opA;
      SEL_LINK:  nextPc = raVal;
      default:   nextPc = pcQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ      <= '0;
      bufInstr <= '0;
      bufPc    <= '0;
    end else begin
      pcQ <= nextPc;
      if (ctl.bufLoad) begin
        bufInstr <= ctl.squash ? '0 : fetchInstr;
        bufPc    <= pcQ;
      end
    end
  end

  // R9: a held control word leaves address and buffer untouched
  p_hold_pc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sel == SEL_HOLD && !ctl.bufLoad) |=>
      (pcQ == $past(pcQ) && bufInstr == $past(bufInstr) && bufPc == $past(bufPc)));

  // R8: a squashing load always leaves a no-operation word in decode
  p_squash_noop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.bufLoad && ctl.squash) |=> (bufInstr == '0));

  // R3: a taken skip lands two words past its own address
  p_skip_dist_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sel == SEL_SKIP2) |=> (pcQ == $past(bufPc) + TWO));

  // R2: sequential flow advances by exactly one word
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sel == SEL_SEQ) |=> (pcQ == $past(pcQ) + ONE));

  // R2: a non-squashing load records the address it was fetched from
  p_buf_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.bufLoad && !ctl.squash) |=> (bufPc == $past(pcQ)));

endmodule

// File: rtl/npc_control.sv
module npc_control
  import npc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     stall,
  input  logic [3:0] opcode,
  input  logic [3:0] mode,
  input  logic     neFlag,
  input  logic     leFlag,
  output npc_ctl_t ctl,
  output logic     halted
);

  logic haltQ;
  logic haltSet;
  logic skipTaken;

  always_comb begin
    case (mode)
      MODE_NE: skipTaken = neFlag;
      MODE_LE: skipTaken = leFlag;
      default: skipTaken = 1'b0;
    endcase
  end

  always_comb begin
    ctl     = '{sel: SEL_SEQ, bufLoad: 1'b1, squash: 1'b0, flush: 1'b0};
    haltSet = 1'b0;
    if (stall) begin
      ctl = '{sel: SEL_HOLD, bufLoad: 1'b0, squash: 1'b0, flush: 1'b0};
    end else if (haltQ) begin
      ctl = '{sel: SEL_HOLD, bufLoad: 1'b1, squash: 1'b1, flush: 1'b0};
    end else begin
      case (opcode)
        OPC_SKIP: begin
          if (skipTaken) begin
            ctl = '{sel: SEL_SKIP2, bufLoad: 1'b1, squash: 1'b1, flush: 1'b1};
          end
        end
        OPC_JUMP: ctl = '{sel: SEL_ABS,  bufLoad: 1'b1, squash: 1'b1, flush: 1'b1};
        OPC_CALL: ctl = '{sel: SEL_REGA, bufLoad: 1'b1, squash: 1'b1, flush: 1'b1};
        OPC_RET:  ctl = '{sel: SEL_LINK, bufLoad: 1'b1, squash: 1'b1, flush: 1'b1};
        OPC_HALT: begin
          ctl     = '{sel: SEL_HOLD, bufLoad: 1'b1, squash: 1'b1, flush: 1'b0};
          haltSet = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) haltQ <= 1'b0;
    else if (haltSet) haltQ <= 1'b1;
  end

  assign halted = haltQ;

  // R9: no redirect strobe while the pipeline is frozen
  p_no_flush_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !ctl.flush);

  // R10: halt is sticky until reset
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    haltQ |=> haltQ);

  // R4: undefined skip modes never redirect
  p_bad_mode_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == OPC_SKIP && mode != MODE_NE && mode != MODE_LE) |-> !ctl.flush);

  // R8: the strobe comes only from a control-flow word
  p_flush_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |-> (opcode == OPC_SKIP || opcode == OPC_JUMP ||
                   opcode == OPC_CALL || opcode == OPC_RET));

endmodule

// File: rtl/fetch_redirect_unit.sv
module fetch_redirect_unit
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int JMP_W = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            stall,
  input  logic [XLEN-1:0] fetchInstr,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [XLEN-1:0] raVal,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] decInstr,
  output logic [XLEN-1:0] decPc,
  output logic [XLEN-1:0] nextPc,
  output logic            flush,
  output logic            halted,
  output logic [XLEN-1:0] linkValue
);

  npc_ctl_t   ctl;
  logic [3:0] opcode;
  logic [3:0] mode;
  logic       neFlag;
  logic       leFlag;

  npc_control ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .stall  (stall),
    .opcode (opcode),
    .mode   (mode),
    .neFlag (neFlag),
    .leFlag (leFlag),
    .ctl    (ctl),
    .halted (halted)
  );

  npc_datapath #(.XLEN(XLEN), .JMP_W(JMP_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .fetchInstr (fetchInstr),
    .opA        (opA),
    .opB        (opB),
    .raVal      (raVal),
    .pcQ        (pc),
    .bufInstr   (decInstr),
    .bufPc      (decPc),
    .nextPc     (nextPc),
    .linkValue  (linkValue),
    .opcode     (opcode),
    .mode       (mode),
    .neFlag     (neFlag),
    .leFlag     (leFlag)
  );

  assign flush = ctl.flush;

  // R10: once halted, the fetch address never moves
  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (halted && $past(halted)) |-> (pc == $past(pc)));

endmodule

// File: tb/fetch_redirect_unit_tb_top.sv
module fetch_redirect_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stall = 1'b0;
  logic [31:0] fetchInstr = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] raVal = '0;
  logic [31:0] pc, decInstr, decPc, nextPc, linkValue;
  logic        flush, halted;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [31:0] FILLER = 32'h1000_0007;

  always #2 clk = ~clk;

  fetch_redirect_unit dut_i (
    .clk(clk), .rstN(rstN), .stall(stall), .fetchInstr(fetchInstr),
    .opA(opA), .opB(opB), .raVal(raVal), .pc(pc), .decInstr(decInstr),
    .decPc(decPc), .nextPc(nextPc), .flush(flush), .halted(halted),
    .linkValue(linkValue)
  );

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] ra;
    logic        expFlush;
    logic [31:0] expNext;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{32'h0123_0004, 32'h0, 32'h0, 32'h0, 1'b0, 32'h2},               // R2 plain add
    '{32'h3012_0003, 32'h5, 32'h5, 32'h0, 1'b0, 32'h2},               // R3 ne, equal
    '{32'h3012_0003, 32'h5, 32'h6, 32'h0, 1'b1, 32'h2},               // R3 ne, differ
    '{32'h3112_0003, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1, 32'h2},       // R4 -1 <= 0
    '{32'h3112_0003, 32'h7, 32'h7, 32'h0, 1'b1, 32'h2},               // R4 equal
    '{32'h3112_0003, 32'h8, 32'h7, 32'h0, 1'b0, 32'h2},               // R4 greater
    '{32'h3112_0003, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0, 1'b1, 32'h2}, // R4 min <= max
    '{32'h3112_0003, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0, 1'b0, 32'h2}, // R4 max > min
    '{32'h3212_0003, 32'h1, 32'h2, 32'h0, 1'b0, 32'h2},               // R4 mode 2
    '{32'h3F12_0003, 32'h1, 32'h2, 32'h0, 1'b0, 32'h2},               // R4 mode 15
    '{32'h40AB_CDEF, 32'h9, 32'h9, 32'h0, 1'b1, 32'h00AB_CDEF},       // R5
    '{32'h40FF_FFFF, 32'h0, 32'h0, 32'h0, 1'b1, 32'h00FF_FFFF},       // R5 all ones field
    '{32'hC500_0000, 32'h0000_1234, 32'h0, 32'h77, 1'b1, 32'h0000_1234}, // R6
    '{32'hD000_0000, 32'h55, 32'h0, 32'h000B_AD00, 1'b1, 32'h000B_AD00}, // R7
    '{32'h5300_0040, 32'h0, 32'h0, 32'h0, 1'b0, 32'h2},               // R2 address load
    '{32'h8312_0005, 32'h0, 32'h0, 32'h0, 1'b0, 32'h2}                // R2 load word
  };
  string tagOf [NVEC] = '{"R2", "R3", "R3", "R4", "R4", "R4", "R4", "R4",
                          "R4", "R4", "R5", "R5", "R6", "R7", "R2", "R2"};

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; stall = 1'b0; fetchInstr = '0; opA = '0; opB = '0; raVal = '0;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Decode one row: word enters at address 0, then is resolved with pc at 1
  task automatic runVec(input vec_t v, input string tag);
    doReset();
    fetchInstr = v.instr;
    @(posedge clk); #1;
    @(negedge clk);
    fetchInstr = FILLER; opA = v.a; opB = v.b; raVal = v.ra;
    #1;
    chk(tag, "flush", 32'(flush), 32'(v.expFlush));
    chk(tag, "nextPc", nextPc, v.expNext);
    chk("R6", "linkValue", linkValue, 32'h1);
    @(posedge clk); #1;
    chk(tag, "pc after edge", pc, v.expNext);
    chk("R8", "decode word after edge", decInstr, v.expFlush ? 32'h0 : FILLER);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    doReset();
    #1;
    chk("R1", "pc", pc, 32'h0);
    chk("R1", "decInstr", decInstr, 32'h0);
    chk("R1", "decPc", decPc, 32'h0);
    chk("R1", "halted", 32'(halted), 32'h0);
    chk("R1", "flush", 32'(flush), 32'h0);

    // R2: straight-line fetch of three words
    for (int k = 0; k < 3; k++) begin
      fetchInstr = FILLER + 32'(k);
      @(posedge clk); #1;
      chk("R2", "pc step", pc, 32'(k + 1));
      chk("R2", "decPc", decPc, 32'(k));
      chk("R2", "decInstr", decInstr, FILLER + 32'(k));
      @(negedge clk);
    end
    // R3: taken skip at address 3
    fetchInstr = 32'h3012_0003;
    @(posedge clk);
    @(negedge clk);
    fetchInstr = FILLER; opA = 32'h1; opB = 32'h2; #1;
    chk("R3", "skip target at 3", nextPc, 32'h5);
    chk("R8", "skip flush at 3", 32'(flush), 32'h1);
    @(posedge clk);
    @(negedge clk);
    // R6: call at address 5, link is 6
    fetchInstr = 32'hC300_0000;
    @(posedge clk);
    @(negedge clk);
    fetchInstr = FILLER; opA = 32'h100; #1;
    chk("R6", "link at 5", linkValue, 32'h6);
    chk("R6", "call target", nextPc, 32'h100);
    @(posedge clk); #1;
    chk("R6", "pc after call", pc, 32'h100);
    chk("R8", "call squash", decInstr, 32'h0);

    // Table walk
    for (int i = 0; i < NVEC; i++) runVec(VEC[i], tagOf[i]);

    // R9: jump held under stall, then released
    doReset();
    fetchInstr = 32'h4000_0321;
    @(posedge clk);
    @(negedge clk);
    stall = 1'b1; fetchInstr = FILLER; #1;
    chk("R9", "flush under stall", 32'(flush), 32'h0);
    chk("R9", "nextPc under stall", nextPc, 32'h1);
    @(posedge clk); #1;
    chk("R9", "pc held", pc, 32'h1);
    chk("R9", "decInstr held", decInstr, 32'h4000_0321);
    chk("R9", "decPc held", decPc, 32'h0);
    @(negedge clk);
    stall = 1'b0; #1;
    chk("R9", "flush after release", 32'(flush), 32'h1);
    chk("R9", "target after release", nextPc, 32'h321);
    @(posedge clk); #1;
    chk("R9", "pc after release", pc, 32'h321);
    chk("R8", "squash after release", decInstr, 32'h0);

    // R10: halt stops fetch
    doReset();
    fetchInstr = 32'hF000_0000;
    @(posedge clk);
    @(negedge clk);
    fetchInstr = FILLER; #1;
    chk("R10", "no flush on halt", 32'(flush), 32'h0);
    chk("R10", "not yet halted", 32'(halted), 32'h0);
    @(posedge clk); #1;
    chk("R10", "halted set", 32'(halted), 32'h1);
    chk("R10", "pc frozen", pc, 32'h1);
    chk("R10", "decode empty", decInstr, 32'h0);
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "still halted", 32'(halted), 32'h1);
    chk("R10", "pc still frozen", pc, 32'h1);
    chk("R10", "nextPc frozen", nextPc, 32'h1);
    chk("R10", "decode still empty", decInstr, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule